// File: doc/BRIEF.md
# Quad DAC Output Latch Controller

This block owns the input, output and persistent shadow registers of a four-channel converter. It decides in which clock cycle each channel's output register takes the value held in its input register. A write that has finished on the serial bus arrives as a one-cycle strobe. The strobe carries a channel index, the channel word and a per-write hold flag. A clear hold flag moves the word straight through to the output. A set hold flag parks the word in the input register.

Parked words reach the outputs in one of two ways. The first is an active-low transfer pin shared by all channels, which is synchronised inside the block. The second is a broadcast update command decoded from the bus general-call address. Two other broadcast commands change channel state. Wake-up clears the power-down field of every channel. Reset reloads every channel from the persistent shadow image.

A write marked persistent also copies the word into the shadow image. It then starts a timed programming interval, and the ready output stays low for that interval. A persistent request that arrives while programming is still running is refused.

Top module: `dac_latch_ctrl`

## Requirements
- R1: A write strobe (`wr_valid`) with `wr_hold`=0 stores `wr_word` in both the input and the output register of channel `wr_ch`. The new value is visible on `out_words` after the capturing clock edge. Channel k occupies `out_words[16k+15:16k]`. Each word is laid out as bits [15:14] power-down field, bit [13] gain, bit [12] reference select and bits [11:0] code.
- R2: A write with `wr_hold`=1 updates only the input register of that channel. That channel's output does not change until a transfer occurs.
- R3: `gc_update` copies all four input registers into their output registers at the next edge. Channels that were not written are copied as well.
- R4: `latch_n` passes through a two-stage synchroniser. A low level driven before edge e0 causes a transfer of all channels at edge e0+2. A transfer then occurs at every edge while the synchronised level stays low.
- R5: `gc_wakeup` clears bits [15:14] in the input and output registers of every channel and keeps the other bits.
- R6: `gc_reset` loads every input and output register from the shadow image as it stood before that edge. It overrides any write, transfer or wake-up in the same cycle.
- R7: A persistent write (`wr_persist`=1) that arrives while `ready`=1 copies the word into the channel's shadow entry. `ready` then reads 0 for exactly PROG_CYCLES cycles.
- R8: A persistent write that arrives while `ready`=0 leaves the shadow image unchanged. Its volatile effect on the input and output registers still applies.
- R9: After reset all input, output and shadow registers are zero and `ready` is 1.
- R10: In a cycle with both a write and a transfer, the write is applied first, so the output takes the new word. A wake-up in that same cycle is applied after the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | One-cycle strobe: a channel write has completed |
| wr_ch | input | 2 | Channel index of the write |
| wr_word | input | 16 | Channel word: power-down, gain, reference select, code |
| wr_hold | input | 1 | 1 = keep the output until a transfer, 0 = load the output at once |
| wr_persist | input | 1 | Also program the word into the shadow image |
| latch_n | input | 1 | Asynchronous active-low transfer pin for all channels |
| gc_reset | input | 1 | Broadcast reset: reload all channels from the shadow image |
| gc_wakeup | input | 1 | Broadcast wake-up: clear every power-down field |
| gc_update | input | 1 | Broadcast update: transfer all channels |
| out_words | output | 64 | Output registers of the four channels, packed |
| ready | output | 1 | Low while shadow programming runs |

## Verification
A wrong input register stays hidden until the next transfer, so every parked-word test ends with a pin or broadcast transfer that exposes the value on `out_words` in the following cycle. A wrong shadow entry shows up only when a broadcast reset reloads it. The bench therefore issues that reset after refused and accepted persistent writes. A miscounted programming timer shows on `ready` at the first or last cycle of the busy window. A wrong synchroniser depth moves the first transfer by a whole cycle. The reference model is compared with the outputs on every clock, so any such error is reported in the cycle it reaches the ports.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;
    localparam int CODE_W = 12;

    typedef struct packed {
        logic [1:0]        pd;
        logic              gain;
        logic              vsel;
        logic [CODE_W-1:0] code;
    } chan_t;

    localparam int WORD_W = $bits(chan_t);
endpackage

// File: rtl/dac_latch_sync.sv
module dac_latch_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic low
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = pin_n;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], pin_n};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign low = !sh_q[STAGES-1];
endmodule

// File: rtl/dac_prog_timer.sv
module dac_prog_timer #(
    parameter int CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)             cnt_d = CNT_W'(CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/dac_latch_ctrl.sv
module dac_latch_ctrl
    import dac_latch_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int PROG_CYCLES = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        wr_valid,
    input  logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] wr_ch,
    input  logic [WORD_W-1:0]                           wr_word,
    input  logic                                        wr_hold,
    input  logic                                        wr_persist,
    input  logic                                        latch_n,
    input  logic                                        gc_reset,
    input  logic                                        gc_wakeup,
    input  logic                                        gc_update,
    output logic [NUM_CH*WORD_W-1:0]                    out_words,
    output logic                                        ready
);
    typedef struct packed {
        chan_t [NUM_CH-1:0] inr;
        chan_t [NUM_CH-1:0] outr;
        chan_t [NUM_CH-1:0] shd;
    } state_t;

    state_t st_d, st_q;
    logic   lat_low;
    logic   busy;
    logic   ch_ok;
    logic   persist_go;

    dac_latch_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (latch_n),
        .low   (lat_low)
    );

    dac_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (persist_go),
        .busy  (busy)
    );

    assign ch_ok      = (int'(wr_ch) < NUM_CH);
    assign persist_go = wr_valid && wr_persist && ch_ok && !busy;

    always_comb begin
        st_d = st_q;
        // channel write first
        if (wr_valid && ch_ok) begin
            st_d.inr[wr_ch] = chan_t'(wr_word);
            if (!wr_hold) st_d.outr[wr_ch] = chan_t'(wr_word);
        end
        // global transfer sees this cycle's write
        if (gc_update || lat_low) st_d.outr = st_d.inr;
        // wake-up after the transfer
        if (gc_wakeup) begin
            for (int k = 0; k < NUM_CH; k++) begin
                st_d.inr[k].pd  = '0;
                st_d.outr[k].pd = '0;
            end
        end
        // broadcast reset overrides everything else
        if (gc_reset) begin
            st_d.inr  = st_q.shd;
            st_d.outr = st_q.shd;
        end
        if (persist_go) st_d.shd[wr_ch] = chan_t'(wr_word);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_words = st_q.outr;
    assign ready     = !busy;
endmodule

// File: rtl/dac_latch_chk.sv
module dac_latch_chk
    import dac_latch_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           wr_valid,
    input logic [((NUM_CH > 1) ? $clog2(NUM_CH) : 1)-1:0] wr_ch,
    input logic [WORD_W-1:0]              wr_word,
    input logic                           wr_hold,
    input logic                           wr_persist,
    input logic                           gc_reset,
    input logic                           gc_wakeup,
    input logic                           gc_update,
    input logic                           lat_low,
    input logic [NUM_CH*WORD_W-1:0]       out_words,
    input logic                           ready
);
    logic              arm_q;
    int                ch_q;
    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q  <= 1'b0;
            ch_q   <= 0;
            word_q <= '0;
        end else begin
            arm_q  <= wr_valid && !wr_hold && !gc_reset && !gc_wakeup;
            ch_q   <= int'(wr_ch);
            word_q <= wr_word;
        end
    end

    function automatic logic any_pd(input logic [NUM_CH*WORD_W-1:0] v);
        logic r;
        r = 1'b0;
        for (int k = 0; k < NUM_CH; k++) r = r | (|v[k*WORD_W + WORD_W - 2 +: 2]);
        return r;
    endfunction

    p_direct_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> out_words[ch_q*WORD_W +: WORD_W] == word_q);

    p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_valid && !wr_hold) && !gc_update && !lat_low && !gc_reset && !gc_wakeup)
        |=> $stable(out_words));

    p_wake_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gc_wakeup && !gc_reset) |=> !any_pd(out_words));

    p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_persist && ready) |=> !ready);

    p_no_spurious_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !(wr_valid && wr_persist)) |=> ready);
endmodule

bind dac_latch_ctrl dac_latch_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_ch      (wr_ch),
    .wr_word    (wr_word),
    .wr_hold    (wr_hold),
    .wr_persist (wr_persist),
    .gc_reset   (gc_reset),
    .gc_wakeup  (gc_wakeup),
    .gc_update  (gc_update),
    .lat_low    (lat_low),
    .out_words  (out_words),
    .ready      (ready)
);

// File: tb/tb_dac_latch_ctrl.sv
module tb_dac_latch_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH        = 4;
    localparam int PROG       = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_valid, wr_hold, wr_persist;
    logic [1:0]  wr_ch;
    logic [15:0] wr_word;
    logic        latch_n, gc_reset, gc_wakeup, gc_update;
    logic [63:0] out_words;
    logic        ready;

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R9";

    // reference model state
    logic [15:0] m_in  [NCH];
    logic [15:0] m_out [NCH];
    logic [15:0] m_sh  [NCH];
    logic        m_s0, m_s1;
    int          m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_latch_ctrl #(.NUM_CH(NCH), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ch(wr_ch),
        .wr_word(wr_word), .wr_hold(wr_hold), .wr_persist(wr_persist),
        .latch_n(latch_n), .gc_reset(gc_reset), .gc_wakeup(gc_wakeup),
        .gc_update(gc_update), .out_words(out_words), .ready(ready)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCH; k++) begin
                m_in[k] = '0; m_out[k] = '0; m_sh[k] = '0;
            end
            m_s0 = 1'b1; m_s1 = 1'b1; m_cnt = 0;
        end else begin
            bit low, go;
            logic [15:0] old_sh [NCH];
            low = !m_s1;
            m_s1 = m_s0;
            m_s0 = latch_n;
            go = wr_valid && wr_persist && (m_cnt == 0);
            for (int k = 0; k < NCH; k++) old_sh[k] = m_sh[k];
            if (wr_valid) begin
                m_in[wr_ch] = wr_word;
                if (!wr_hold) m_out[wr_ch] = wr_word;
            end
            if (gc_update || low)
                for (int k = 0; k < NCH; k++) m_out[k] = m_in[k];
            if (gc_wakeup)
                for (int k = 0; k < NCH; k++) begin
                    m_in[k][15:14] = 2'b00; m_out[k][15:14] = 2'b00;
                end
            if (gc_reset)
                for (int k = 0; k < NCH; k++) begin
                    m_in[k] = old_sh[k]; m_out[k] = old_sh[k];
                end
            if (go) begin
                m_sh[wr_ch] = wr_word; m_cnt = PROG;
            end else if (m_cnt > 0) m_cnt--;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            logic [63:0] exp;
            for (int k = 0; k < NCH; k++) exp[k*16 +: 16] = m_out[k];
            chk(out_words === exp, cur_req, out_words, exp);
            chk(ready === (m_cnt == 0), cur_req, {63'd0, ready}, {63'd0, m_cnt == 0});
        end
    end

    function automatic logic [15:0] och(input int k);
        return out_words[k*16 +: 16];
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        wr_valid = 0; wr_hold = 0; wr_persist = 0; wr_ch = 0; wr_word = 0;
        gc_reset = 0; gc_wakeup = 0; gc_update = 0;
    endtask

    task automatic wr(input int ch, input logic [15:0] w, input bit hold, input bit pers);
        wr_valid = 1; wr_ch = 2'(ch); wr_word = w; wr_hold = hold; wr_persist = pers;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int lowc;
        rst_n = 0; latch_n = 1; idle();
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R9 reset state
        chk(out_words === 64'd0, "R9", out_words, 0);
        chk(ready === 1'b1, "R9", {63'd0, ready}, 1);

        cur_req = "R1";
        wr(2, 16'h2ABC, 0, 0); cyc(1); idle();
        chk(och(2) === 16'h2ABC, "R1", och(2), 16'h2ABC);

        cur_req = "R2";
        wr(1, 16'h1111, 1, 0); cyc(1); idle();
        chk(och(1) === 16'h0000, "R2", och(1), 0);

        cur_req = "R3";
        gc_update = 1; cyc(1); gc_update = 0;
        chk(och(1) === 16'h1111, "R3", och(1), 16'h1111);

        cur_req = "R4";
        wr(0, 16'h0A0A, 1, 0); cyc(1);
        wr(3, 16'h3C3C, 1, 0); cyc(1); idle();
        latch_n = 0; cyc(1); latch_n = 1; cyc(1);
        chk(och(0) === 16'h0000, "R4", och(0), 0);
        cyc(1);
        chk(och(0) === 16'h0A0A, "R4", och(0), 16'h0A0A);
        chk(och(3) === 16'h3C3C, "R4", och(3), 16'h3C3C);
        latch_n = 0; cyc(2);
        wr(0, 16'h0B0B, 1, 0); cyc(1); idle();
        chk(och(0) === 16'h0B0B, "R4", och(0), 16'h0B0B);
        latch_n = 1; cyc(3);

        cur_req = "R10";
        wr(1, 16'h1234, 1, 0); gc_update = 1; cyc(1); idle();
        chk(och(1) === 16'h1234, "R10", och(1), 16'h1234);
        wr(2, 16'h8765, 1, 0); gc_update = 1; gc_wakeup = 1; cyc(1); idle();
        chk(och(2) === 16'h0765, "R10", och(2), 16'h0765);

        cur_req = "R5";
        wr(0, 16'hC123, 0, 0); cyc(1); idle();
        chk(och(0) === 16'hC123, "R5", och(0), 16'hC123);
        gc_wakeup = 1; cyc(1); gc_wakeup = 0;
        chk(och(0) === 16'h0123, "R5", och(0), 16'h0123);
        wr(2, 16'h4DEF, 1, 0); cyc(1); idle();
        gc_wakeup = 1; cyc(1); gc_wakeup = 0;
        gc_update = 1; cyc(1); gc_update = 0;
        chk(och(2) === 16'h0DEF, "R5", och(2), 16'h0DEF);

        cur_req = "R7";
        wr(3, 16'h3AAA, 0, 1); cyc(1); idle();
        chk(ready === 1'b0, "R7", {63'd0, ready}, 0);
        cur_req = "R8";
        wr(3, 16'h0555, 0, 1); cyc(1); idle();
        chk(och(3) === 16'h0555, "R8", och(3), 16'h0555);
        lowc = 2;
        cur_req = "R7";
        while (ready === 1'b0 && lowc < 200) begin
            cyc(1);
            if (ready === 1'b0) lowc++;
        end
        chk(lowc == PROG, "R7", 64'(lowc), 64'(PROG));

        cur_req = "R6";
        gc_reset = 1; cyc(1); gc_reset = 0;
        chk(och(3) === 16'h3AAA, "R8", och(3), 16'h3AAA);
        chk(och(0) === 16'h0000, "R6", och(0), 0);
        wr(1, 16'h1999, 0, 0); gc_update = 1; gc_reset = 1; cyc(1); idle();
        chk(och(1) === 16'h0000, "R6", och(1), 0);
        cyc(2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule